// File: doc/BRIEF.md
# ADC Autoscan Sequencing Controller

This block drives an external successive-approximation converter across a set of up to eight analog channels. Software chooses which channels take part by writing a channel mask. A scan then visits every selected channel once, starting from the lowest-numbered one and working upward. For each conversion the controller issues a start pulse and a channel number, waits for the converter's done strobe, and captures the 10-bit result in a buffer register reserved for that channel.

A scan can be started by a software write or by an edge on an external start pin. The pin passes through a synchronizer, and it can be set to respond to rising edges, falling edges, both, or neither. In one-time mode the busy status drops after the last selected channel has been converted. In continuous mode the status stays set and the scan wraps around to the lowest selected channel. Each pass that completes sets a completion interrupt flag. Hardware never clears this flag; only software does. While the flag is set, any new start request is held back and takes effect once software clears the flag.

Register map: address 0 is control/status. Address 1 is the channel mask, bits 7..0. Addresses 8..15 are the read-only result buffers for channels 0..7, with the result right-aligned.

Top module: `adc_scan_ctrl`

## Requirements
- R1: A channel takes part in a scan only when its bit in the mask (address 1, bit n for channel n) is 1. Channels whose mask bit is 0 are never sent to the converter.
- R2: A scan visits the selected channels in strictly ascending order, beginning at the lowest set mask bit.
- R3: Each completed conversion stores the converter result in that channel's buffer, readable at address 8+n in bits 9..0.
- R4: Writing 1 to control bit 0 (go) starts a scan when the block is idle and the interrupt flag is clear. Control bit 0 reads back as the effective busy status, and a start pulse is issued only while busy.
- R5: Control bit 3 enables starts on a rising edge of the external start pin, and control bit 4 enables starts on a falling edge. With both bits 0 the pin has no effect.
- R6: The interrupt flag (control bit 1, also driven on irq) is set when the last selected channel's result is stored. It stays set until software writes 1 to control bit 1.
- R7: In one-time mode (control bit 2 = 0) the busy status returns to 0 after the last selected channel completes, and the interrupt flag is set in that same cycle. With a single mask bit set, this happens after every conversion.
- R8: In continuous mode (control bit 2 = 1) the busy status stays 1 and the scan restarts from the lowest selected channel after the highest one. Clearing control bit 2 lets the current pass finish as a one-time scan.
- R9: A start request from software or from the pin that arrives while the interrupt flag is 1 is held pending. No conversion runs and the busy status reads 0 until software clears the flag, after which the held scan begins.
- R10: A start with an all-zero mask sets the interrupt flag without issuing any conversion.
- R11: A change of the mask during a scan is applied at the next channel selection, so the scan continues with the next set bit of the new mask above the current channel.
- R12: The converter start pulse is high for exactly one clock cycle per conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| ext_start | input | 1 | External start pin (asynchronous) |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 3 | Channel for the converter to sample |
| conv_done | input | 1 | Converter done strobe, result valid |
| conv_result | input | 10 | Converter result |
| irq | output | 1 | Sticky completion interrupt flag |

## Verification
A corrupted channel index or mask decode shows up at the converter handshake. It appears on conv_chan at the very next start pulse, either as a skipped, repeated or out-of-order channel, or as a result landing in the wrong buffer. A faulty sequencing state appears within one conversion latency as a missing start pulse, a busy status that fails to drop, or an irq flag that is missing or cleared by hardware. A faulty pending latch is visible within a few cycles of the flag being cleared: either the held scan never starts, or a scan starts while the flag is still set.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SELECT  = 2'd1,
    ST_CONVERT = 2'd2
  } scan_state_e;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_MASK = 1;
  localparam int ADDR_RES  = 8;

  localparam int BIT_GO   = 0;
  localparam int BIT_IRQ  = 1;
  localparam int BIT_CONT = 2;
  localparam int BIT_RISE = 3;
  localparam int BIT_FALL = 4;
endpackage

// File: rtl/adc_start_sync.sv
module adc_start_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], pin_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NCH = 8,
  localparam int IDX_W = $clog2(NCH),
  localparam int CW = IDX_W + 1
) (
  input  logic [NCH-1:0]   mask_i,
  input  logic [CW-1:0]    from_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask_i[i] && (i >= int'(from_i))) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH = 8,
  parameter int RES_W = 10,
  localparam int IDX_W = $clog2(NCH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           sel_i,
  input  logic [RES_W-1:0]           data_i,
  output logic [NCH-1:0][RES_W-1:0]  res_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_slot
    logic en;
    assign en = we_i && (sel_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  res_o[g] <= '0;
      else if (en) res_o[g] <= data_i;
    end
  end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NCH = 8,
  parameter int RES_W = 10,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(NCH),
  localparam int CW = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_start,
  output logic              conv_start,
  output logic [IDX_W-1:0]  conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic              irq
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_ff;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_n_s = rst_ff[1];

  // configuration and status state
  scan_state_e        state_q, state_d;
  logic               active_q, active_d;
  logic               irq_q, irq_d;
  logic               pend_q, pend_d;
  logic               cont_q, rise_en_q, fall_en_q;
  logic [NCH-1:0]     mask_q;
  logic [CW-1:0]      cur_q, cur_d;
  logic [IDX_W-1:0]   chan_q, chan_d;
  logic               start_q, start_d;

  logic ctrl_wr, mask_wr, sw_go, irq_clr, ext_go, go_req, launch, irq_set, res_we;
  logic ext_rise, ext_fall;
  logic pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic [CW-1:0]    pick_from;
  logic [NCH-1:0][RES_W-1:0] res_all;
  logic unused_wdata;

  assign ctrl_wr = reg_we && (int'(reg_addr) == ADDR_CTRL);
  assign mask_wr = reg_we && (int'(reg_addr) == ADDR_MASK);
  assign sw_go   = ctrl_wr && reg_wdata[BIT_GO];
  assign irq_clr = ctrl_wr && reg_wdata[BIT_IRQ];
  assign unused_wdata = ^reg_wdata[DATA_W-1:NCH];

  adc_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .pin_i(ext_start),
    .rise_o(ext_rise), .fall_o(ext_fall)
  );

  assign ext_go = (rise_en_q && ext_rise) || (fall_en_q && ext_fall);
  assign go_req = sw_go || ext_go || pend_q;
  assign launch = !active_q && !irq_q && go_req;

  // in CONVERT look above the current channel, otherwise from the scan pointer
  assign pick_from = (state_q == ST_CONVERT) ? (CW'(chan_q) + CW'(1)) : cur_q;

  adc_chan_pick #(.NCH(NCH)) u_pick (
    .mask_i(mask_q), .from_i(pick_from),
    .found_o(pick_found), .idx_o(pick_idx)
  );

  adc_result_bank #(.NCH(NCH), .RES_W(RES_W)) u_bank (
    .clk(clk), .rst_n(rst_n_s), .we_i(res_we), .sel_i(chan_q),
    .data_i(conv_result), .res_o(res_all)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    active_d = active_q;
    cur_d    = cur_q;
    chan_d   = chan_q;
    start_d  = 1'b0;
    irq_set  = 1'b0;
    res_we   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (launch) begin
          state_d  = ST_SELECT;
          active_d = 1'b1;
          cur_d    = '0;
        end
      end
      ST_SELECT: begin
        if (pick_found) begin
          chan_d  = pick_idx;
          start_d = 1'b1;
          state_d = ST_CONVERT;
        end else begin
          irq_set = 1'b1;
          cur_d   = '0;
          if (!cont_q) begin
            state_d  = ST_IDLE;
            active_d = 1'b0;
          end
        end
      end
      ST_CONVERT: begin
        if (conv_done) begin
          res_we = 1'b1;
          if (pick_found) begin
            cur_d   = CW'(chan_q) + CW'(1);
            state_d = ST_SELECT;
          end else begin
            irq_set = 1'b1;
            cur_d   = '0;
            if (cont_q) begin
              state_d = ST_SELECT;
            end else begin
              state_d  = ST_IDLE;
              active_d = 1'b0;
            end
          end
        end
      end
      default: begin
        state_d  = ST_IDLE;
        active_d = 1'b0;
      end
    endcase
    irq_d  = irq_set ? 1'b1 : (irq_clr ? 1'b0 : irq_q);
    pend_d = !active_q && irq_q && go_req;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q  <= ST_IDLE;
      active_q <= 1'b0;
      irq_q    <= 1'b0;
      pend_q   <= 1'b0;
      cur_q    <= '0;
      chan_q   <= '0;
      start_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      active_q <= active_d;
      irq_q    <= irq_d;
      pend_q   <= pend_d;
      cur_q    <= cur_d;
      chan_q   <= chan_d;
      start_q  <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cont_q    <= 1'b0;
      rise_en_q <= 1'b0;
      fall_en_q <= 1'b0;
    end else if (ctrl_wr) begin
      cont_q    <= reg_wdata[BIT_CONT];
      rise_en_q <= reg_wdata[BIT_RISE];
      fall_en_q <= reg_wdata[BIT_FALL];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     mask_q <= '0;
    else if (mask_wr) mask_q <= reg_wdata[NCH-1:0];
  end

  // read port
  always_comb begin
    reg_rdata = '0;
    if (int'(reg_addr) == ADDR_CTRL) begin
      reg_rdata[BIT_GO]   = active_q;
      reg_rdata[BIT_IRQ]  = irq_q;
      reg_rdata[BIT_CONT] = cont_q;
      reg_rdata[BIT_RISE] = rise_en_q;
      reg_rdata[BIT_FALL] = fall_en_q;
    end else if (int'(reg_addr) == ADDR_MASK) begin
      reg_rdata[NCH-1:0] = mask_q;
    end else if ((int'(reg_addr) >= ADDR_RES) && (int'(reg_addr) < ADDR_RES + NCH)) begin
      reg_rdata[RES_W-1:0] = res_all[IDX_W'(int'(reg_addr) - ADDR_RES)];
    end
  end

  assign conv_start = start_q;
  assign conv_chan  = chan_q;
  assign irq        = irq_q;
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_start,
  input logic irq,
  input logic busy,
  input logic irq_clr
);
  assert_start_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  assert_pend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !busy) |=> !busy);

  assert_end_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .conv_start(conv_start), .irq(irq),
  .busy(active_q), .irq_clr(irq_clr)
);

// File: tb/sim_adc_scan_ctrl.sv
`timescale 1ns/1ps
module sim_adc_scan_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        ext_start = 1'b0;
  logic        conv_start;
  logic [2:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_result = 10'd0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int log_n = 0;
  int seq = 1;
  int log_ch [0:255];
  int exp_res [0:7];

  always #2 clk = ~clk;

  adc_scan_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_start(ext_start),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_result(conv_result), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // converter model: answers each start pulse after a few cycles
  initial begin
    forever begin
      @(negedge clk);
      if (conv_start) begin
        int ch;
        int v;
        ch = int'(conv_chan);
        v = (ch << 7) | (seq & 8'h7f);
        seq++;
        if (log_n < 256) log_ch[log_n] = ch;
        log_n++;
        @(negedge clk);
        chk(conv_start == 1'b0, "R12 start pulse width", int'(conv_start), 0);
        repeat (2) @(negedge clk);
        conv_result = 10'(v);
        conv_done = 1'b1;
        exp_res[ch] = v;
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = 4'(a);
    #0.5;
    d = int'(reg_rdata);
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 500) begin @(negedge clk); n++; end
    chk(irq == 1'b1, req, int'(irq), 1);
  endtask

  task automatic check_order(input int mask, input int first, input string req);
    int k = first;
    for (int i = 0; i < 8; i++) begin
      if (mask[i]) begin
        chk(k < log_n && log_ch[k] == i, req, (k < log_n) ? log_ch[k] : -1, i);
        k++;
      end
    end
    chk(log_n == k, req, log_n, k);
  endtask

  task automatic t_reset;
    int d;
    rd(0, d); chk(d == 0, "R7 reset ctrl", d, 0);
    rd(1, d); chk(d == 0, "R1 reset mask", d, 0);
    chk(irq == 1'b0, "R6 reset irq", int'(irq), 0);
  endtask

  task automatic t_oneshot;
    int d;
    int first = log_n;
    wr(1, 8'hA4);
    wr(0, 1);                           // R4 software go
    wait_irq("R6 irq at scan end");
    repeat (2) @(negedge clk);
    check_order(8'hA4, first, "R1 R2 selected channels ascending");
    for (int c = 0; c < 8; c++) begin
      if (c == 2 || c == 5 || c == 7) begin
        rd(8 + c, d); chk(d == exp_res[c], "R3 result buffer", d, exp_res[c]);
      end
    end
    rd(0, d); chk(d[0] == 1'b0, "R7 busy cleared one-time", d & 1, 0);
    repeat (20) @(negedge clk);
    chk(irq == 1'b1, "R6 irq sticky", int'(irq), 1);
    wr(0, 2);
    chk(irq == 1'b0, "R6 irq cleared by write", int'(irq), 0);
  endtask

  task automatic t_single;
    int d;
    int first = log_n;
    wr(1, 8'h10);
    wr(0, 1);
    wait_irq("R7 single channel irq");
    repeat (2) @(negedge clk);
    chk(log_n == first + 1 && log_ch[first] == 4, "R7 single conversion", log_n - first, 1);
    rd(0, d); chk(d[0] == 1'b0, "R7 single busy cleared", d & 1, 0);
    wr(0, 2);
  endtask

  task automatic t_pending;
    int d;
    int first;
    wr(1, 8'h01);
    wr(0, 1);
    wait_irq("R9 setup irq");
    repeat (6) @(negedge clk);
    first = log_n;
    wr(0, 1);
    repeat (20) @(negedge clk);
    chk(log_n == first, "R9 no conversion while irq set", log_n - first, 0);
    rd(0, d); chk(d[0] == 1'b0, "R9 status reads 0 while pending", d & 1, 0);
    wr(0, 2);
    repeat (3) @(negedge clk);
    chk(log_n == first + 1, "R9 held start runs after clear", log_n - first, 1);
    wait_irq("R9 held scan completes");
    wr(0, 2);
  endtask

  task automatic t_ext;
    int first;
    wr(1, 8'h02);
    wr(0, 8);                           // rising edge only
    first = log_n;
    @(negedge clk); ext_start = 1'b1;
    repeat (20) @(negedge clk);
    chk(log_n == first + 1 && irq, "R5 rising edge starts", log_n - first, 1);
    wr(0, 8 | 2);
    first = log_n;
    @(negedge clk); ext_start = 1'b0;
    repeat (20) @(negedge clk);
    chk(log_n == first && !irq, "R5 falling edge ignored when rising only", log_n - first, 0);
    wr(0, 16);                          // falling edge only
    first = log_n;
    @(negedge clk); ext_start = 1'b1;
    repeat (20) @(negedge clk);
    chk(log_n == first, "R5 rising edge ignored when falling only", log_n - first, 0);
    @(negedge clk); ext_start = 1'b0;
    repeat (20) @(negedge clk);
    chk(log_n == first + 1 && irq, "R5 falling edge starts", log_n - first, 1);
    wr(0, 2);                           // both disabled
    first = log_n;
    @(negedge clk); ext_start = 1'b1;
    repeat (20) @(negedge clk); ext_start = 1'b0;
    repeat (20) @(negedge clk);
    chk(log_n == first && !irq, "R5 pin disabled", log_n - first, 0);
  endtask

  task automatic t_cont;
    int d;
    int first = log_n;
    int n = 0;
    wr(1, 8'h03);
    wr(0, 4 | 1);
    while (log_n < first + 5 && n < 1000) begin @(negedge clk); n++; end
    rd(0, d); chk(d[0] == 1'b1, "R8 busy stays set", d & 1, 1);
    for (int k = 0; k < 5; k++)
      chk(log_ch[first + k] == (k % 2), "R8 restart from lowest", log_ch[first + k], k % 2);
    chk(irq == 1'b1, "R8 irq per pass", int'(irq), 1);
    wr(0, 2);                           // leave continuous mode, clear irq
    n = 0;
    rd(0, d);
    while (d[0] && n < 200) begin @(negedge clk); n++; rd(0, d); end
    chk(d[0] == 1'b0 && irq, "R8 pass ends after leaving continuous", d & 1, 0);
    chk(log_ch[log_n - 1] == 1, "R8 last pass ends on top channel", log_ch[log_n - 1], 1);
    wr(0, 2);
  endtask

  task automatic t_zero;
    int d;
    int first = log_n;
    wr(1, 0);
    wr(0, 1);
    repeat (4) @(negedge clk);
    chk(irq == 1'b1, "R10 empty mask sets irq", int'(irq), 1);
    chk(log_n == first, "R10 no conversion", log_n - first, 0);
    rd(0, d); chk(d[0] == 1'b0, "R10 idle after empty scan", d & 1, 0);
    wr(0, 2);
  endtask

  task automatic t_maskchg;
    int first = log_n;
    int n = 0;
    wr(1, 8'h0F);
    wr(0, 1);
    while (log_n == first && n < 100) begin @(negedge clk); n++; end
    wr(1, 8'h0A);
    wait_irq("R11 scan completes");
    repeat (2) @(negedge clk);
    chk(log_n == first + 3, "R11 conversion count", log_n - first, 3);
    chk(log_ch[first] == 0, "R11 first channel", log_ch[first], 0);
    chk(log_ch[first + 1] == 1, "R11 new mask next", log_ch[first + 1], 1);
    chk(log_ch[first + 2] == 3, "R11 new mask skip", log_ch[first + 2], 3);
    wr(0, 2);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_oneshot;
    t_single;
    t_pending;
    t_ext;
    t_cont;
    t_zero;
    t_maskchg;
    repeat (10) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule